// File: doc/BRIEF.md
# Configuration Space Access Gateway

This block is the host-side front end of the two-port configuration access method. An I/O bus master writes a 32-bit target selector to an address port. It then reads or writes a data port. While the selector's enable bit is set, each full-dword data-port access becomes a configuration access. That access targets the bus, device, function and dword register named in the selector. Accesses to bus 0, device 0 are served by a small local header in the same cycle. Any other target is handed to a downstream generator over a request/response pair, and the I/O access stalls until the response returns.

The local header belongs to a multi-function device.
- Function 0 carries a read-only identifier, a command/status pair, a header-type byte, a write-once subsystem identifier dword and a gate bit.
- The gate bit decides whether functions 1 to 7 are visible.
- Hidden functions read as all ones and ignore writes.
- The status word holds four error flags. Event pulses set them, and software clears them by writing ones.

Top module: `cfgspace_gateway`

## Requirements
- R1: The address port stores the selector with enable in bit 31, bus in bits 23:16, device in bits 15:11, function in bits 10:8 and dword index in bits 7:2; bits 30:24 and 1:0 always read back as zero.
- R2: Only accesses with all four byte enables set are claimed at the two port addresses. Any narrower access is left unclaimed and changes no state.
- R3: A data-port access is claimed only while the stored enable bit is 1.
- R4: A data-port access to bus 0, device 0 completes in the cycle it is presented and issues no downstream request.
- R5: A data-port access to any other bus or device raises the downstream request for exactly one cycle, carrying the selector fields, the direction and the write data. The I/O access holds ready low until the response-valid arrives, and a read returns the response data.
- R6: Bit 24 of local dword 13h (byte offset 4Fh, bit 0) is the multi-function gate, and it resets to 0. While it is 0, every read of functions 1 to 7 returns FFFFFFFFh. Writes to functions 1 to 7 never change any state.
- R7: Bits 23:16 of local dword 03h (header-type byte, offset 0Eh) read 80h while the gate is 1 and 00h while it is 0.
- R8: Local dword 0Bh (subsystem vendor ID in bits 15:0, subsystem ID in bits 31:16) takes the first write after reset. Later writes are ignored.
- R9: Status bits 31 (parity detected), 29 (master abort received), 28 (target abort received) and 24 (master data parity error) in local dword 01h are set by their event inputs. Writing 1 clears such a bit, and writing 0 leaves it unchanged.
- R10: The master data parity error bit can be set only while command bit 6 (parity error response) is 1. The writable command bits are 0, 1, 2, 6 and 8.
- R11: Reset clears the selector, the subsystem write lock and value, the gate bit and all status bits.
- R12: Local dword 00h returns {DEVICE_ID, VENDOR_ID} and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | I/O access present; held until io_ready |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | I/O port address |
| io_be | input | 4 | Byte enables |
| io_wdata | input | 32 | Write data |
| io_claim | output | 1 | Access is taken by this block |
| io_ready | output | 1 | Claimed access completes this cycle |
| io_rdata | output | 32 | Read data of a claimed read |
| ev_perr_det | input | 1 | Parity error detected event |
| ev_mabort | input | 1 | Master abort received event |
| ev_tabort | input | 1 | Target abort received event |
| ev_mdpe | input | 1 | Master data parity error event |
| fwd_valid | output | 1 | Downstream configuration request |
| fwd_wr | output | 1 | Request direction |
| fwd_bus | output | 8 | Target bus |
| fwd_dev | output | 5 | Target device |
| fwd_fn | output | 3 | Target function |
| fwd_reg | output | 6 | Target dword index |
| fwd_wdata | output | 32 | Request write data |
| rsp_valid | input | 1 | Downstream response present |
| rsp_rdata | input | 32 | Downstream read data |

## Verification
The bound checker watches several properties on every cycle:
- that nothing narrower than a dword is ever claimed, and that data-port claims occur only with the enable bit set;
- that local accesses never raise the downstream request, and that the request is a single-cycle pulse with ready held low;
- the all-ones reads of hidden functions;
- that the parity-error flag rises only with the response enable on;
- that the subsystem dword is frozen once locked.

Only the bench's scenarios can show that values round-trip through the header, and that one-to-clear writes leave zero bits untouched. They also show the gate's effect on the header-type byte, that forwarded fields match the selector, and that reset restores a writable subsystem dword.

// File: rtl/cfg_gw_pkg.sv
package cfg_gw_pkg;

  typedef struct packed {
    logic       en;
    logic [6:0] rsv;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dw;
    logic [1:0] lo;
  } cfg_addr_t;

  localparam logic [31:0] ADDR_KEEP = 32'h80FF_FFFC;
  localparam logic [15:0] STAT_W1C  = 16'hB100;
  localparam logic [15:0] CMD_WMASK = 16'h0147;

  localparam int ST_PERR = 15;
  localparam int ST_MABT = 13;
  localparam int ST_TABT = 12;
  localparam int ST_MDPE = 8;
  localparam int CMD_PERR_EN = 6;

  localparam logic [5:0] DW_ID  = 6'h00;
  localparam logic [5:0] DW_CMD = 6'h01;
  localparam logic [5:0] DW_HDR = 6'h03;
  localparam logic [5:0] DW_SUB = 6'h0B;
  localparam logic [5:0] DW_MF  = 6'h13;

  function automatic cfg_addr_t addr_sanitize(input logic [31:0] w);
    return cfg_addr_t'(w & ADDR_KEEP);
  endfunction

  function automatic logic targets_local(input cfg_addr_t a);
    return (a.bus == 8'd0) && (a.dev == 5'd0);
  endfunction

  function automatic logic [15:0] status_update(input logic [15:0] cur,
                                                input logic [15:0] ones,
                                                input logic [15:0] evt);
    return (cur & ~(ones & STAT_W1C)) | (evt & STAT_W1C);
  endfunction

  function automatic logic [31:0] hdr_type_word(input logic mf);
    return {8'h00, (mf ? 8'h80 : 8'h00), 16'h0000};
  endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic             io_valid,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [3:0]       io_be,
  input  logic             addr_en,
  output logic             hit_addr,
  output logic             hit_data
);
  logic full_dw;
  assign full_dw  = (io_be == 4'hF);
  assign hit_addr = io_valid && full_dw && (io_addr == ADDR_PORT);
  assign hit_data = io_valid && full_dw && (io_addr == DATA_PORT) && addr_en;
endmodule

// File: rtl/cfg_fwd_ctrl.sv
module cfg_fwd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic rsp_valid,
  output logic fwd_valid,
  output logic done
);
  logic busy_q;
  assign fwd_valid = req && !busy_q;
  assign done      = busy_q && rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n)         busy_q <= 1'b0;
    else if (fwd_valid) busy_q <= 1'b1;
    else if (done)      busy_q <= 1'b0;
  end
endmodule

// File: rtl/cfg_local_hdr.sv
module cfg_local_hdr import cfg_gw_pkg::*; #(
  parameter logic [15:0] VENDOR_ID = 16'hABCD,
  parameter logic [15:0] DEVICE_ID = 16'h5A00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  fn,
  input  logic [5:0]  dw,
  input  logic [31:0] wdata,
  input  logic        ev_perr_det,
  input  logic        ev_mabort,
  input  logic        ev_tabort,
  input  logic        ev_mdpe,
  output logic [31:0] rdata,
  output logic        mf_en,
  output logic        cmd_perr_en,
  output logic        stat_mdpe,
  output logic        ss_locked,
  output logic [31:0] ss_val
);
  localparam logic [31:0] ID_WORD = {DEVICE_ID, VENDOR_ID};

  logic [15:0] cmd_q, stat_q, evt, clr_ones;
  logic [31:0] ss_q;
  logic        ss_lock_q, mf_q, wr_f0;

  assign wr_f0 = wr_en && (fn == 3'd0);

  always_comb begin
    evt          = '0;
    evt[ST_PERR] = ev_perr_det;
    evt[ST_MABT] = ev_mabort;
    evt[ST_TABT] = ev_tabort;
    evt[ST_MDPE] = ev_mdpe && cmd_q[CMD_PERR_EN];
  end

  assign clr_ones = (wr_f0 && dw == DW_CMD) ? wdata[31:16] : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      stat_q    <= '0;
      ss_q      <= '0;
      ss_lock_q <= 1'b0;
      mf_q      <= 1'b0;
    end else begin
      stat_q <= status_update(stat_q, clr_ones, evt);
      if (wr_f0 && dw == DW_CMD) cmd_q <= wdata[15:0] & CMD_WMASK;
      if (wr_f0 && dw == DW_SUB && !ss_lock_q) begin
        ss_q      <= wdata;
        ss_lock_q <= 1'b1;
      end
      if (wr_f0 && dw == DW_MF) mf_q <= wdata[24];
    end
  end

  always_comb begin
    rdata = '0;
    if (fn == 3'd0) begin
      case (dw)
        DW_ID:   rdata = ID_WORD;
        DW_CMD:  rdata = {stat_q, cmd_q};
        DW_HDR:  rdata = hdr_type_word(mf_q);
        DW_SUB:  rdata = ss_q;
        DW_MF:   rdata = {7'd0, mf_q, 24'd0};
        default: rdata = '0;
      endcase
    end else if (!mf_q) begin
      rdata = '1;
    end else begin
      case (dw)
        DW_ID:   rdata = ID_WORD;
        DW_HDR:  rdata = hdr_type_word(mf_q);
        default: rdata = '0;
      endcase
    end
  end

  assign mf_en       = mf_q;
  assign cmd_perr_en = cmd_q[CMD_PERR_EN];
  assign stat_mdpe   = stat_q[ST_MDPE];
  assign ss_locked   = ss_lock_q;
  assign ss_val      = ss_q;
endmodule

// File: rtl/cfgspace_gateway.sv
module cfgspace_gateway import cfg_gw_pkg::*; #(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC,
  parameter logic [15:0] VENDOR_ID = 16'hABCD,
  parameter logic [15:0] DEVICE_ID = 16'h5A00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_valid,
  input  logic             io_wr,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [3:0]       io_be,
  input  logic [31:0]      io_wdata,
  output logic             io_claim,
  output logic             io_ready,
  output logic [31:0]      io_rdata,
  input  logic             ev_perr_det,
  input  logic             ev_mabort,
  input  logic             ev_tabort,
  input  logic             ev_mdpe,
  output logic             fwd_valid,
  output logic             fwd_wr,
  output logic [7:0]       fwd_bus,
  output logic [4:0]       fwd_dev,
  output logic [2:0]       fwd_fn,
  output logic [5:0]       fwd_reg,
  output logic [31:0]      fwd_wdata,
  input  logic             rsp_valid,
  input  logic [31:0]      rsp_rdata
);
  cfg_addr_t   addr_q;
  logic        addr_en, hit_addr, hit_data, local_hit, remote_hit, fwd_done;
  logic [2:0]  acc_fn;
  logic [31:0] hdr_rdata, ss_val;
  logic        mf_en, cmd_perr_en, stat_mdpe, ss_locked;

  assign addr_en = addr_q.en;
  assign acc_fn  = addr_q.fn;

  cfg_port_decode #(.IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) i_dec (
    .io_valid(io_valid), .io_addr(io_addr), .io_be(io_be), .addr_en(addr_en),
    .hit_addr(hit_addr), .hit_data(hit_data)
  );

  assign local_hit  = hit_data && targets_local(addr_q);
  assign remote_hit = hit_data && !targets_local(addr_q);

  always_ff @(posedge clk) begin
    if (!rst_n)                addr_q <= '0;
    else if (hit_addr && io_wr) addr_q <= addr_sanitize(io_wdata);
  end

  cfg_fwd_ctrl i_fwd (
    .clk(clk), .rst_n(rst_n), .req(remote_hit), .rsp_valid(rsp_valid),
    .fwd_valid(fwd_valid), .done(fwd_done)
  );

  cfg_local_hdr #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) i_hdr (
    .clk(clk), .rst_n(rst_n), .wr_en(local_hit && io_wr),
    .fn(addr_q.fn), .dw(addr_q.dw), .wdata(io_wdata),
    .ev_perr_det(ev_perr_det), .ev_mabort(ev_mabort), .ev_tabort(ev_tabort), .ev_mdpe(ev_mdpe),
    .rdata(hdr_rdata), .mf_en(mf_en), .cmd_perr_en(cmd_perr_en), .stat_mdpe(stat_mdpe),
    .ss_locked(ss_locked), .ss_val(ss_val)
  );

  assign io_claim = hit_addr || hit_data;
  assign io_ready = remote_hit ? fwd_done : 1'b1;

  always_comb begin
    if (hit_addr)        io_rdata = 32'(addr_q);
    else if (local_hit)  io_rdata = hdr_rdata;
    else if (remote_hit) io_rdata = rsp_rdata;
    else                 io_rdata = '0;
  end

  assign fwd_wr    = io_wr;
  assign fwd_bus   = addr_q.bus;
  assign fwd_dev   = addr_q.dev;
  assign fwd_fn    = addr_q.fn;
  assign fwd_reg   = addr_q.dw;
  assign fwd_wdata = io_wdata;
endmodule

// File: rtl/cfg_gateway_chk.sv
module cfg_gateway_chk #(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_wr,
  input logic [IO_AW-1:0] io_addr,
  input logic [3:0]       io_be,
  input logic             io_claim,
  input logic             io_ready,
  input logic [31:0]      io_rdata,
  input logic             fwd_valid,
  input logic             addr_en,
  input logic             local_hit,
  input logic [2:0]       acc_fn,
  input logic             mf_en,
  input logic             stat_mdpe,
  input logic             cmd_perr_en,
  input logic             ss_locked,
  input logic [31:0]      ss_val
);
  assert_addr_rsvd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_claim && !io_wr && io_addr == ADDR_PORT) |-> (io_rdata[30:24] == 7'd0 && io_rdata[1:0] == 2'd0));

  assert_dword_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    io_claim |-> (io_be == 4'hF));

  assert_data_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_claim && io_addr == DATA_PORT) |-> addr_en);

  assert_local_no_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    local_hit |-> (!fwd_valid && io_ready));

  assert_fwd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |=> !fwd_valid);

  assert_fwd_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !io_ready);

  assert_hidden_fn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (local_hit && !io_wr && acc_fn != 3'd0 && !mf_en) |-> (io_rdata == 32'hFFFF_FFFF));

  assert_subsys_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ss_locked) |-> $stable(ss_val));

  assert_mdpe_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_mdpe) |-> $past(cmd_perr_en));
endmodule

bind cfgspace_gateway cfg_gateway_chk #(.IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) i_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_be(io_be),
  .io_claim(io_claim), .io_ready(io_ready), .io_rdata(io_rdata), .fwd_valid(fwd_valid),
  .addr_en(addr_en), .local_hit(local_hit), .acc_fn(acc_fn), .mf_en(mf_en),
  .stat_mdpe(stat_mdpe), .cmd_perr_en(cmd_perr_en), .ss_locked(ss_locked), .ss_val(ss_val)
);

// File: tb/test_cfgspace_gateway.sv
module test_cfgspace_gateway;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] AP = 16'h0CF8;
  localparam logic [15:0] DP = 16'h0CFC;
  localparam logic [31:0] IDW = 32'h5A00_ABCD;
  localparam logic [31:0] RSP_WORD = 32'h0BAD_F00D;

  typedef struct packed {
    logic        wr;
    logic [15:0] port;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic        claim;
    logic [31:0] rdata;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{1'b1, AP, 4'hF, 32'hFFFF_FFFF, 1'b1, 32'h0, 4'd1},        // R1 write all ones
    '{1'b0, AP, 4'hF, 32'h0,         1'b1, 32'h80FF_FFFC, 4'd1}, // R1 reserved read zero
    '{1'b1, AP, 4'h3, 32'h0,         1'b0, 32'h0, 4'd2},        // R2 word write unclaimed
    '{1'b0, AP, 4'hF, 32'h0,         1'b1, 32'h80FF_FFFC, 4'd2}, // R2 selector untouched
    '{1'b1, AP, 4'hF, 32'h0,         1'b1, 32'h0, 4'd3},        // R3 disable
    '{1'b0, DP, 4'hF, 32'h0,         1'b0, 32'h0, 4'd3},        // R3 data unclaimed
    '{1'b1, AP, 4'hF, 32'h8000_0000, 1'b1, 32'h0, 4'd4},        // R4
    '{1'b0, DP, 4'hF, 32'h0,         1'b1, IDW,   4'd4},        // R4 local ID
    '{1'b1, DP, 4'hF, 32'h1234_5678, 1'b1, 32'h0, 4'd12},       // R12 write ID
    '{1'b0, DP, 4'hF, 32'h0,         1'b1, IDW,   4'd12},       // R12 unchanged
    '{1'b0, DP, 4'h1, 32'h0,         1'b0, 32'h0, 4'd2},        // R2 byte read
    '{1'b1, AP, 4'hF, 32'h8000_000C, 1'b1, 32'h0, 4'd7},        // R7
    '{1'b0, DP, 4'hF, 32'h0,         1'b1, 32'h0, 4'd7},        // R7 type 00h
    '{1'b1, AP, 4'hF, 32'h8000_0100, 1'b1, 32'h0, 4'd6},        // R6 fn1
    '{1'b0, DP, 4'hF, 32'h0,         1'b1, 32'hFFFF_FFFF, 4'd6}, // R6 hidden
    '{1'b1, AP, 4'hF, 32'h8000_004C, 1'b1, 32'h0, 4'd6},        // R6 gate dword
    '{1'b1, DP, 4'hF, 32'h0100_0000, 1'b1, 32'h0, 4'd6},        // R6 open gate
    '{1'b0, DP, 4'hF, 32'h0,         1'b1, 32'h0100_0000, 4'd6}, // R6
    '{1'b1, AP, 4'hF, 32'h8000_000C, 1'b1, 32'h0, 4'd7},        // R7
    '{1'b0, DP, 4'hF, 32'h0,         1'b1, 32'h0080_0000, 4'd7}, // R7 type 80h
    '{1'b1, AP, 4'hF, 32'h8000_0100, 1'b1, 32'h0, 4'd6},        // R6
    '{1'b0, DP, 4'hF, 32'h0,         1'b1, IDW,   4'd6},        // R6 fn1 visible
    '{1'b1, AP, 4'hF, 32'h8000_010C, 1'b1, 32'h0, 4'd7},        // R7
    '{1'b0, DP, 4'hF, 32'h0,         1'b1, 32'h0080_0000, 4'd7}, // R7 fn1 type
    '{1'b1, AP, 4'hF, 32'h8000_002C, 1'b1, 32'h0, 4'd8},        // R8
    '{1'b1, DP, 4'hF, 32'hCAFE_0001, 1'b1, 32'h0, 4'd8},        // R8 first write
    '{1'b0, DP, 4'hF, 32'h0,         1'b1, 32'hCAFE_0001, 4'd8}, // R8
    '{1'b1, DP, 4'hF, 32'h0000_BEEF, 1'b1, 32'h0, 4'd8},        // R8 second write
    '{1'b0, DP, 4'hF, 32'h0,         1'b1, 32'hCAFE_0001, 4'd8}, // R8 kept
    '{1'b1, AP, 4'hF, 32'h8000_004C, 1'b1, 32'h0, 4'd6},        // R6
    '{1'b1, DP, 4'hF, 32'h0,         1'b1, 32'h0, 4'd6},        // R6 close gate
    '{1'b1, AP, 4'hF, 32'h8000_014C, 1'b1, 32'h0, 4'd6},        // R6 fn1 4Ch
    '{1'b1, DP, 4'hF, 32'h0100_0000, 1'b1, 32'h0, 4'd6},        // R6 dropped write
    '{1'b0, DP, 4'hF, 32'h0,         1'b1, 32'hFFFF_FFFF, 4'd6}, // R6 still hidden
    '{1'b1, AP, 4'hF, 32'h8000_004C, 1'b1, 32'h0, 4'd6},        // R6
    '{1'b0, DP, 4'hF, 32'h0,         1'b1, 32'h0, 4'd6}         // R6 gate stays 0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_valid = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [3:0] io_be = '0;
  logic [31:0] io_wdata = '0;
  logic io_claim, io_ready;
  logic [31:0] io_rdata;
  logic ev_perr_det = 1'b0, ev_mabort = 1'b0, ev_tabort = 1'b0, ev_mdpe = 1'b0;
  logic fwd_valid, fwd_wr;
  logic [7:0] fwd_bus;
  logic [4:0] fwd_dev;
  logic [2:0] fwd_fn;
  logic [5:0] fwd_reg;
  logic [31:0] fwd_wdata;
  logic rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;

  int total = 0, bad = 0;
  logic f_seen, f_stall, f_wr;
  logic [7:0] f_bus;
  logic [4:0] f_dev;
  logic [2:0] f_fn;
  logic [5:0] f_reg;
  logic [31:0] f_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgspace_gateway i_cfgspace_gateway (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_wr(io_wr), .io_addr(io_addr),
    .io_be(io_be), .io_wdata(io_wdata), .io_claim(io_claim), .io_ready(io_ready),
    .io_rdata(io_rdata), .ev_perr_det(ev_perr_det), .ev_mabort(ev_mabort),
    .ev_tabort(ev_tabort), .ev_mdpe(ev_mdpe), .fwd_valid(fwd_valid), .fwd_wr(fwd_wr),
    .fwd_bus(fwd_bus), .fwd_dev(fwd_dev), .fwd_fn(fwd_fn), .fwd_reg(fwd_reg),
    .fwd_wdata(fwd_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic io_do(input logic wr, input logic [15:0] port, input logic [3:0] be,
                       input logic [31:0] wd, output logic claim, output logic [31:0] rd);
    @(negedge clk);
    io_valid = 1'b1; io_wr = wr; io_addr = port; io_be = be; io_wdata = wd;
    f_seen = 1'b0; f_stall = 1'b0;
    #1;
    claim = io_claim;
    if (io_claim && fwd_valid) begin
      f_seen = 1'b1; f_wr = fwd_wr; f_bus = fwd_bus; f_dev = fwd_dev;
      f_fn = fwd_fn; f_reg = fwd_reg; f_wdata = fwd_wdata;
      @(negedge clk); #1;
      f_stall = !fwd_valid && !io_ready;
      @(negedge clk);
      rsp_valid = 1'b1; rsp_rdata = RSP_WORD;
      #1;
    end
    rd = io_rdata;
    @(posedge clk); #1;
    io_valid = 1'b0; rsp_valid = 1'b0;
  endtask

  task automatic cfg_rd(input logic [31:0] sel, output logic [31:0] rd);
    logic c;
    logic [31:0] d;
    io_do(1'b1, AP, 4'hF, sel, c, d);
    io_do(1'b0, DP, 4'hF, 32'h0, c, rd);
  endtask

  task automatic cfg_wr(input logic [31:0] sel, input logic [31:0] wd);
    logic c;
    logic [31:0] d;
    io_do(1'b1, AP, 4'hF, sel, c, d);
    io_do(1'b1, DP, 4'hF, wd, c, d);
  endtask

  task automatic pulse(input logic perr, input logic mab, input logic tab, input logic mdpe);
    @(negedge clk);
    ev_perr_det = perr; ev_mabort = mab; ev_tabort = tab; ev_mdpe = mdpe;
    @(negedge clk);
    ev_perr_det = 0; ev_mabort = 0; ev_tabort = 0; ev_mdpe = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic c;
    logic [31:0] d;
    do_reset();
    // R11: reset state
    io_do(1'b0, AP, 4'hF, 32'h0, c, d);
    check("R11 selector after reset", d, 32'h0);
    cfg_rd(32'h8000_002C, d);
    check("R11 subsystem after reset", d, 32'h0);
    cfg_rd(32'h8000_0004, d);
    check("R11 status after reset", d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      io_do(VECS[i].wr, VECS[i].port, VECS[i].be, VECS[i].wdata, c, d);
      check($sformatf("R%0d claim vec%0d", VECS[i].req, i), {31'd0, c}, {31'd0, VECS[i].claim});
      if (VECS[i].claim && !VECS[i].wr)
        check($sformatf("R%0d data vec%0d", VECS[i].req, i), d, VECS[i].rdata);
    end

    // R4: local read raised no request
    cfg_rd(32'h8000_0000, d);
    check("R4 no forward on local", {31'd0, f_seen}, 32'd0);

    // R9 / R10: status behaviour
    pulse(1'b0, 1'b1, 1'b0, 1'b1);
    cfg_rd(32'h8000_0004, d);
    check("R10 mdpe blocked, R9 mabort set", d, 32'h2000_0000);
    cfg_wr(32'h8000_0004, 32'h0000_FFFF);
    cfg_rd(32'h8000_0004, d);
    check("R9 zero writes keep status, R10 cmd mask", d, 32'h2000_0147);
    cfg_wr(32'h8000_0004, 32'h0000_0040);
    pulse(1'b1, 1'b0, 1'b1, 1'b1);
    cfg_rd(32'h8000_0004, d);
    check("R10 mdpe set with enable", d, 32'hB100_0040);
    cfg_wr(32'h8000_0004, 32'h2000_0040);
    cfg_rd(32'h8000_0004, d);
    check("R9 clear one bit", d, 32'h9100_0040);
    cfg_wr(32'h8000_0004, 32'h9100_0040);
    cfg_rd(32'h8000_0004, d);
    check("R9 clear rest", d, 32'h0000_0040);

    // R5: forwarded read
    cfg_rd(32'h8012_3A04, d);
    check("R5 fwd read seen", {31'd0, f_seen}, 32'd1);
    check("R5 fwd read data", d, RSP_WORD);
    check("R5 stall and single pulse", {31'd0, f_stall}, 32'd1);
    check("R5 fields", {12'd0, f_wr, f_bus, f_dev, f_fn, f_reg}, {12'd0, 1'b0, 8'h12, 5'd7, 3'd2, 6'd1});
    // R5: forwarded write to bus 0 device 1
    cfg_wr(32'h8000_0800, 32'h5555_AAAA);
    check("R5 fwd write seen", {31'd0, f_seen}, 32'd1);
    check("R5 fwd write dir/dev", {26'd0, f_wr, f_dev}, {26'd0, 1'b1, 5'd1});
    check("R5 fwd write data", f_wdata, 32'h5555_AAAA);

    // R11 / R8: reset mid-run unlocks subsystem and clears status
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    do_reset();
    io_do(1'b0, AP, 4'hF, 32'h0, c, d);
    check("R11 selector cleared", d, 32'h0);
    cfg_rd(32'h8000_0004, d);
    check("R11 status cleared", d, 32'h0);
    cfg_wr(32'h8000_002C, 32'h1111_2222);
    cfg_rd(32'h8000_002C, d);
    check("R8 write accepted after reset", d, 32'h1111_2222);
    cfg_rd(32'h8000_0100, d);
    check("R11 gate cleared, R6 hidden", d, 32'hFFFF_FFFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule